// File: doc/BRIEF.md
# Ratio-Coded System Clock Divider

This block turns one fast source clock into four system clock-enable streams: core, high-speed bus, low-speed bus and memory. It also produces a fifth enable for a half-rate tap of the source. No derived clocks are built. Each stream is a train of one-cycle pulses, so logic in each domain runs on the source clock and qualifies its registers with its enable.

A single 32-bit control word holds one 4-bit ratio code per domain. Each code indexes a fixed, non-uniform table of divide ratios (1, 2, 3, 4, 6, 8, 12, 16, 24, 32). Codes past the end of the table clamp to the largest ratio. Software writes the word through a byte-masked write port and can read it back at any time.

A newly written code affects the pulse trains only when the word's change-enable flag is set. A domain then switches to its new ratio at the next terminal pulse of its old ratio. As a result no pulse gap is ever cut short.

Top module: `sysclk_ratio_divider`

## Requirements
- R1: After reset the control word reads 0, all four domain enables are high in every cycle (ratio 1), and the half-rate tap enable is low in the first cycle after reset.
- R2: A write replaces only the bytes whose strobe bit is set (strobe bit b covers data bits 8b+7..8b). The read port returns the stored word from the cycle after the write.
- R3: Domain d (0 core, 1 high-speed bus, 2 low-speed bus, 3 memory) takes its code from bits 4d+3..4d. Codes 0..9 give exactly one enable pulse every 1, 2, 3, 4, 6, 8, 12, 16, 24 or 32 source cycles respectively.
- R4: Any code of 10 to 15 gives one pulse every 32 source cycles.
- R5: A write whose merged word has bit 22 clear is stored but leaves every domain's pulse spacing unchanged.
- R6: A write whose merged word has bit 22 set stages all four codes one cycle after the write. Each domain keeps its old spacing up to its next terminal pulse and uses the staged ratio from that pulse on.
- R7: With bit 21 set the half-rate tap enable is high every cycle. With bit 21 clear it pulses on alternate cycles.
- R8: Each domain's pulse train depends only on its own code field and on the change-enable history.
- R9: The change-enable flag is taken from the merged word. A write that leaves byte 2 unstrobed uses the stored bit 22.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write request for the control word |
| wr_strb | input | 4 | Per-byte write mask |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Stored control word |
| dom_en | output | 4 | Domain enables: bit0 core, bit1 high-speed bus, bit2 low-speed bus, bit3 memory |
| half_tap_en | output | 1 | Half-rate (or full-rate) tap enable |

## Verification
A counter or staged ratio that goes wrong inside a domain shows up at dom_en within one period of the faulty ratio, at most 32 cycles. It appears as a pulse early, late or missing, and the bench compares every enable against a reference every cycle. A staging fault shows up at the first terminal pulse after a change-enabled write. A register merge fault shows up on rd_data one cycle after the write.

// File: rtl/sclkdiv_pkg.sv
package sclkdiv_pkg;

   typedef enum logic [1:0] {
      DOM_CORE = 2'd0,
      DOM_HBUS = 2'd1,
      DOM_PBUS = 2'd2,
      DOM_MEM  = 2'd3
   } dom_e;

   localparam int unsigned MAX_CODE  = 9;
   localparam int unsigned MAX_RATIO = 32;

   // ratio series: 1,2,3,4 then alternating 3*2^k and 2^k; codes above 9 clamp
   function automatic int unsigned code_to_ratio(input int unsigned code);
      int unsigned c;
      c = (code > MAX_CODE) ? MAX_CODE : code;
      if (c <= 3)
         return c + 1;
      else if ((c % 2) == 0)
         return 3 << ((c - 2) / 2);
      else
         return 1 << ((c + 1) / 2);
   endfunction

endpackage

// File: rtl/sclkdiv_ctrl_reg.sv
module sclkdiv_ctrl_reg #(
   parameter int REG_W  = 32,
   parameter int CE_BIT = 22
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [REG_W/8-1:0] wr_strb,
   input  logic [REG_W-1:0]   wr_data,
   output logic [REG_W-1:0]   word_q,
   output logic               commit_q
);
   localparam int NBYTES = REG_W / 8;

   generate
      if (REG_W % 8 != 0) begin : g_bad_w
         $error("REG_W must be a whole number of bytes");
      end
      if (CE_BIT >= REG_W) begin : g_bad_ce
         $error("CE_BIT outside the control word");
      end
   endgenerate

   logic [REG_W-1:0] merged;

   generate
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
         assign merged[8*b +: 8] = (wr_en && wr_strb[b]) ? wr_data[8*b +: 8]
                                                         : word_q[8*b +: 8];

         p_byte_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && wr_strb[b]) |=> $stable(word_q[8*b +: 8]))
            else $error("unstrobed byte %0d changed", b);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word_q   <= '0;
         commit_q <= 1'b0;
      end else begin
         word_q   <= merged;
         commit_q <= wr_en && merged[CE_BIT];
      end
   end

   p_commit_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      commit_q |-> word_q[CE_BIT])
      else $error("commit without stored change-enable");

endmodule

// File: rtl/sclkdiv_ratio_ctr.sv
module sclkdiv_ratio_ctr
   import sclkdiv_pkg::*;
#(
   parameter int CODE_W = 4,
   parameter int CNT_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stage_req,
   input  logic [CODE_W-1:0] code_in,
   output logic              tick
);
   generate
      if ((1 << CNT_W) <= MAX_RATIO) begin : g_bad_cnt
         $error("CNT_W too narrow for the largest ratio");
      end
   endgenerate

   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  ratio_q;
   logic [CODE_W-1:0] staged_q;
   logic              pend_q;
   logic [CNT_W-1:0]  staged_ratio;

   assign staged_ratio = CNT_W'(code_to_ratio(32'(staged_q)));
   assign tick         = (cnt_q == ratio_q - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         ratio_q  <= CNT_W'(1);
         staged_q <= '0;
         pend_q   <= 1'b0;
      end else begin
         if (tick) begin
            cnt_q <= '0;
            if (pend_q) begin
               ratio_q <= staged_ratio;
               pend_q  <= 1'b0;
            end
         end else begin
            cnt_q <= cnt_q + CNT_W'(1);
         end
         if (stage_req) begin
            staged_q <= code_in;
            pend_q   <= 1'b1;
         end
      end
   end

   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < ratio_q)
      else $error("count escaped its ratio");

   p_ratio_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ratio_q >= CNT_W'(1)) && (ratio_q <= CNT_W'(MAX_RATIO)))
      else $error("ratio outside table range");

   p_switch_at_term_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(ratio_q))
      else $error("ratio changed mid-period");

   p_pend_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && tick && !stage_req) |=> !pend_q)
      else $error("pending update not consumed");

endmodule

// File: rtl/sclkdiv_half_tap.sv
module sclkdiv_half_tap (
   input  logic clk,
   input  logic rst_n,
   input  logic full_rate,
   output logic tick
);
   logic tgl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) tgl_q <= 1'b0;
      else        tgl_q <= ~tgl_q;
   end

   assign tick = full_rate | tgl_q;

   p_alternate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!full_rate && tick) |=> (full_rate || !tick))
      else $error("half tap pulsed twice in a row");

endmodule

// File: rtl/sysclk_ratio_divider.sv
module sysclk_ratio_divider
   import sclkdiv_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter int CODE_W   = 4,
   parameter int NUM_DOM  = 4,
   parameter int CE_BIT   = 22,
   parameter int FULL_BIT = 21
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [REG_W/8-1:0] wr_strb,
   input  logic [REG_W-1:0]   wr_data,
   output logic [REG_W-1:0]   rd_data,
   output logic [NUM_DOM-1:0] dom_en,
   output logic               half_tap_en
);
   localparam int CNT_W = $clog2(MAX_RATIO + 1);

   generate
      if (NUM_DOM * CODE_W > FULL_BIT) begin : g_bad_fields
         $error("code fields overlap the control flags");
      end
      if (FULL_BIT == CE_BIT) begin : g_bad_flags
         $error("flag bits must differ");
      end
   endgenerate

   logic [REG_W-1:0] word_q;
   logic             commit_q;

   sclkdiv_ctrl_reg #(.REG_W(REG_W), .CE_BIT(CE_BIT)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_strb  (wr_strb),
      .wr_data  (wr_data),
      .word_q   (word_q),
      .commit_q (commit_q)
   );

   assign rd_data = word_q;

   generate
      for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
         sclkdiv_ratio_ctr #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_ctr (
            .clk       (clk),
            .rst_n     (rst_n),
            .stage_req (commit_q),
            .code_in   (word_q[CODE_W*d +: CODE_W]),
            .tick      (dom_en[d])
         );
      end
   endgenerate

   sclkdiv_half_tap u_tap (
      .clk       (clk),
      .rst_n     (rst_n),
      .full_rate (word_q[FULL_BIT]),
      .tick      (half_tap_en)
   );

endmodule

// File: tb/sysclk_ratio_divider_tb.sv
module sysclk_ratio_divider_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_strb = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [3:0]  dom_en;
   logic        half_tap_en;

   always #2 clk = ~clk;

   sysclk_ratio_divider u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_strb(wr_strb),
      .wr_data(wr_data), .rd_data(rd_data), .dom_en(dom_en),
      .half_tap_en(half_tap_en)
   );

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   // reference state
   logic [31:0] m_reg = '0;
   logic        m_commit = 0;
   int          m_cnt[4];
   int          m_ratio[4];
   int          m_stg[4];
   bit          m_pend[4];
   bit          m_tgl = 0;
   logic [3:0]  s_en;

   function automatic int ratio_tbl(input int code);
      case (code)
         0: return 1;   1: return 2;   2: return 3;   3: return 4;
         4: return 6;   5: return 8;   6: return 12;  7: return 16;
         8: return 24;  default: return 32;
      endcase
   endfunction

   task automatic chk(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic cycle(input bit we, input logic [31:0] d, input logic [3:0] s,
                        input string tag);
      logic [31:0] merged;
      for (int i = 0; i < 4; i++)
         chk(tag, $sformatf("dom_en[%0d]", i), int'(dom_en[i]),
             int'(m_cnt[i] == m_ratio[i] - 1));
      chk(tag, "half_tap_en", int'(half_tap_en), int'(m_reg[21] | m_tgl));
      chk(tag, "rd_data", int'(rd_data), int'(m_reg));
      s_en = dom_en;
      wr_en = we; wr_data = d; wr_strb = s;
      merged = m_reg;
      if (we)
         for (int b = 0; b < 4; b++)
            if (s[b]) merged[8*b +: 8] = d[8*b +: 8];
      for (int i = 0; i < 4; i++) begin
         if (m_cnt[i] == m_ratio[i] - 1) begin
            m_cnt[i] = 0;
            if (m_pend[i]) begin
               m_ratio[i] = ratio_tbl(m_stg[i]);
               m_pend[i] = 0;
            end
         end else m_cnt[i]++;
         if (m_commit) begin
            m_stg[i] = int'(m_reg[4*i +: 4]);
            m_pend[i] = 1;
         end
      end
      m_commit = we && merged[22];
      m_reg = merged;
      m_tgl = ~m_tgl;
      @(negedge clk);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) cycle(0, '0, '0, tag);
   endtask

   task automatic measure_gap(input int dom, input int exp, input string tag);
      int n = 0;
      int guard = 0;
      do begin cycle(0, '0, '0, tag); guard++; end while (!s_en[dom] && guard < 80);
      do begin cycle(0, '0, '0, tag); n++; end while (!s_en[dom] && n < 80);
      chk(tag, $sformatf("gap dom%0d", dom), n, exp);
   endtask

   initial begin
      for (int i = 0; i < 4; i++) begin
         m_cnt[i] = 0; m_ratio[i] = 1; m_stg[i] = 0; m_pend[i] = 0;
      end
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      idle(4, "R1");

      // R2: byte-masked writes, change-enable clear
      cycle(1, 32'hA5A5_0055, 4'b0001, "R2");
      idle(1, "R2");
      cycle(1, 32'h1133_7700, 4'b1010, "R2");
      idle(2, "R2");

      // R5: codes stored without change-enable leave ratios alone
      cycle(1, 32'h0000_7777, 4'b0011, "R5");
      idle(40, "R5");

      // R3: every table entry, domains offset to keep them distinct
      for (int c = 0; c < 10; c++) begin
         logic [31:0] w;
         w = 32'h0040_0000 | (32'((c + 3) % 10) << 12) | (32'((c + 2) % 10) << 8)
             | (32'((c + 1) % 10) << 4) | 32'(c);
         cycle(1, w, 4'b1111, "R3");
         idle(1, "R3");
         measure_gap(0, ratio_tbl(c), "R3");
         measure_gap(0, ratio_tbl(c), "R3");
         idle(40, "R3");
      end

      // R4: saturating codes
      for (int c = 10; c < 16; c++) begin
         cycle(1, 32'h0040_0000 | (32'(c) * 32'h1111), 4'b1111, "R4");
         idle(1, "R4");
         measure_gap(1, 32, "R4");
         measure_gap(1, 32, "R4");
      end

      // R6: change mid-period from ratio 32 to ratio 2
      cycle(1, 32'h0040_9999, 4'b1111, "R6");
      idle(80, "R6");
      idle(7, "R6");
      cycle(1, 32'h0040_1111, 4'b0111, "R6");
      measure_gap(2, 2, "R6");
      idle(20, "R6");

      // R7: half tap rate select
      cycle(1, 32'h0020_0000, 4'b0100, "R7");
      idle(10, "R7");
      cycle(1, 32'h0000_0000, 4'b0100, "R7");
      idle(10, "R7");

      // R9: change-enable taken from stored bit when byte 2 unstrobed
      cycle(1, 32'h0040_0000, 4'b0100, "R9");
      idle(3, "R9");
      cycle(1, 32'h0000_0002, 4'b0001, "R9");
      idle(2, "R9");
      measure_gap(0, 3, "R9");
      cycle(1, 32'h0000_0000, 4'b0100, "R9");
      cycle(1, 32'h0000_0009, 4'b0001, "R9");
      idle(2, "R9");
      measure_gap(0, 3, "R9");

      // R8: random mix, domains checked independently every cycle
      for (int k = 0; k < 3000; k++) begin
         bit we;
         we = ($urandom % 8) == 0;
         cycle(we, $urandom, 4'($urandom), "R8");
      end
      idle(70, "R8");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule